// File: doc/BRIEF.md
# Serial TDM Link Port

This block joins one receive and one transmit single-ended serial TDM line to the byte-wide slot interface of a switching core. Both directions run on one shared bit clock (`clk`) and one shared frame pulse (`fsync`). Each direction places its frame at its own bit distance from that pulse. This lets lines with unaligned framing work side by side while every line stays locked to the same frame reference. A frame is `SLOTS` slots of eight bits.

On the receive side, serial bits are collected most significant bit first. Each finished byte is handed out with its slot number as a one-cycle beat. The beat cannot be held back, because the line does not stop. The consumer has no ready signal and must take every beat in the cycle it is shown.

On the transmit side, the byte for each slot is requested one slot ahead of its shift-out time. This leaves the switch memory up to seven bit clocks to answer. The answer is a valid/ready beat. Ready is high only while a request is open and the current bit is not a slot boundary, and one accepted beat closes the request. A beat shown while ready is low is dropped. Each answer carries a per-slot drive flag, and a link-level enable can release the line. While the line is not driven, the output enable is low so that other drivers may share the line. A frame pulse at an unexpected bit position raises a slip flag and restarts the counters.

Top module: `tdm_link_port`

## Requirements
- R1: While `rst_n` is low, `rx_valid`, `tx_req_valid`, `tx_rsp_ready`, `tx_oe`, `tx_sd` and `frame_slip` are all 0.
- R2: Until the first `fsync` is sampled high after reset, no byte beat, no transmit request and no line drive is produced. The cycle in which `fsync` is high is the first active cycle and has frame position 0.
- R3: A line's position in a cycle is (frame position − its offset) mod 8·SLOTS, with offsets below 8·SLOTS. On receive, the bit sampled at position 8·s+i is bit 7−i of slot s. After the edge at position 8·s+7, `rx_valid` is high for exactly one cycle with that byte on `rx_data` and s on `rx_slot`.
- R4: After the edge at transmit position 8·s, `tx_req_valid` is high for one cycle with `tx_req_slot` = (s+1) mod SLOTS.
- R5: `tx_rsp_ready` is high exactly when a request is open and the transmit position is not a multiple of 8. A request opens at every slot boundary and closes on an accepted beat (`tx_rsp_valid` and `tx_rsp_ready` both high).
- R6: After the edge at transmit position 8·s+i, `tx_sd` holds bit 7−i of the byte accepted for slot s, and `tx_oe` equals that beat's `tx_rsp_drive`.
- R7: A slot with no accepted beat before its boundary, including a beat shown while ready is low, is not driven: `tx_oe` is 0 for all eight of its bits.
- R8: With `tx_link_en` low at an edge, `tx_oe` is 0 after that edge.
- R9: When `fsync` is high while locked and the expected position is not 0, `frame_slip` is high for one cycle after that edge, and positions restart at 0 in that cycle. When `fsync` comes at the expected position, `frame_slip` stays 0.
- R10: `tx_sd` is 0 whenever `tx_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | shared bit clock |
| rst_n | input | 1 | asynchronous reset, active low |
| fsync | input | 1 | shared frame pulse, one cycle |
| rx_offset | input | clog2(8·SLOTS) | receive line bit offset from the frame pulse |
| tx_offset | input | clog2(8·SLOTS) | transmit line bit offset from the frame pulse |
| tx_link_en | input | 1 | link-level transmit drive enable |
| rx_sd | input | 1 | receive serial data |
| rx_valid | output | 1 | received byte beat |
| rx_data | output | 8 | received byte |
| rx_slot | output | clog2(SLOTS) | slot of the received byte |
| tx_req_valid | output | 1 | request for the next slot's byte |
| tx_req_slot | output | clog2(SLOTS) | requested slot |
| tx_rsp_valid | input | 1 | answer beat valid |
| tx_rsp_ready | output | 1 | answer beat ready |
| tx_rsp_data | input | 8 | byte for the requested slot |
| tx_rsp_drive | input | 1 | drive the line during that slot |
| tx_sd | output | 1 | transmit serial data |
| tx_oe | output | 1 | transmit output enable; low means high impedance |
| frame_slip | output | 1 | frame pulse seen at an unexpected position |

## Verification
The bench builds the block with SLOTS = 4, which makes a frame 32 bits long. Many complete frames therefore fit in a short run. This puts several situations in reach: the offset that wraps around the frame end (31), the request for slot 0 made from the last slot, an early frame pulse, and answers at the earliest, latest and too-late bit of the request window. Offsets, the link enable and the answer delay are changed between phases. A behavioural model compares every output in every cycle.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
  localparam int BITS_PER_SLOT = 8;
  typedef logic [BITS_PER_SLOT-1:0] slot_byte_t;
endpackage

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker #(
  parameter int FRAME_BITS = 256,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [POS_W-1:0] cur_pos,
  output logic             active,
  output logic             slip
);
  logic [POS_W-1:0] phase_q;
  logic             locked_q;

  assign cur_pos = fsync ? '0 : phase_q;
  assign active  = locked_q | fsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      locked_q <= 1'b0;
      slip     <= 1'b0;
    end else begin
      phase_q  <= (cur_pos == POS_W'(FRAME_BITS - 1)) ? '0 : cur_pos + POS_W'(1);
      locked_q <= locked_q | fsync;
      slip     <= fsync & locked_q & (phase_q != '0);
    end
  end
endmodule

// File: rtl/tdm_link_phase.sv
module tdm_link_phase #(
  parameter int SLOTS = 32,
  localparam int FRAME_BITS = SLOTS * 8,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int SLOT_W = POS_W - 3,
  localparam int DW = POS_W + 1
) (
  input  logic [POS_W-1:0]  cur_pos,
  input  logic [POS_W-1:0]  offset,
  output logic [2:0]        bit_idx,
  output logic [SLOT_W-1:0] slot_idx
);
  logic [DW-1:0]    diff;
  logic [POS_W-1:0] lpos;

  always_comb begin
    diff = {1'b0, cur_pos} + DW'(FRAME_BITS) - {1'b0, offset};
    if (diff >= DW'(FRAME_BITS)) lpos = POS_W'(diff - DW'(FRAME_BITS));
    else                         lpos = POS_W'(diff);
  end

  assign bit_idx  = lpos[2:0];
  assign slot_idx = lpos[POS_W-1:3];
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_link_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [2:0]        bit_idx,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              rx_sd,
  output logic              rx_valid,
  output slot_byte_t        rx_data,
  output logic [SLOT_W-1:0] rx_slot
);
  logic [BITS_PER_SLOT-2:0] sh_q;
  logic                     last_bit;

  assign last_bit = active && (bit_idx == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_slot  <= '0;
    end else begin
      rx_valid <= last_bit;
      if (active) sh_q <= {sh_q[BITS_PER_SLOT-3:0], rx_sd};
      if (last_bit) begin
        rx_data <= {sh_q, rx_sd};
        rx_slot <= slot_idx;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_link_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [2:0]        bit_idx,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              link_en,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  slot_byte_t        rsp_data,
  input  logic              rsp_drive,
  output logic              req_valid,
  output logic [SLOT_W-1:0] req_slot,
  output logic              tx_sd,
  output logic              tx_oe
);
  slot_byte_t byte_q, pend_q, sel_byte;
  logic       drive_q, pend_drive_q, pend_v_q, open_q;
  logic       boundary, accept, sel_drive, oe_next;

  assign boundary  = active && (bit_idx == 3'd0);
  assign rsp_ready = open_q && (bit_idx != 3'd0);
  assign accept    = rsp_valid && rsp_ready;

  always_comb begin
    sel_byte  = byte_q;
    sel_drive = drive_q;
    if (boundary) begin
      sel_byte  = pend_v_q ? pend_q : byte_q;
      sel_drive = pend_v_q && pend_drive_q;
    end
    oe_next = active && link_en && sel_drive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q       <= '0;
      drive_q      <= 1'b0;
      pend_q       <= '0;
      pend_drive_q <= 1'b0;
      pend_v_q     <= 1'b0;
      open_q       <= 1'b0;
      req_valid    <= 1'b0;
      req_slot     <= '0;
      tx_sd        <= 1'b0;
      tx_oe        <= 1'b0;
    end else begin
      byte_q  <= sel_byte;
      drive_q <= sel_drive;
      tx_oe   <= oe_next;
      tx_sd   <= oe_next & sel_byte[~bit_idx];
      if (boundary) begin
        pend_v_q  <= 1'b0;
        open_q    <= 1'b1;
        req_valid <= 1'b1;
        req_slot  <= (slot_idx == SLOT_W'(SLOTS - 1)) ? '0 : slot_idx + SLOT_W'(1);
      end else begin
        req_valid <= 1'b0;
        if (accept) begin
          pend_q       <= rsp_data;
          pend_drive_q <= rsp_drive;
          pend_v_q     <= 1'b1;
          open_q       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_link_port.sv
module tdm_link_port
  import tdm_link_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int FRAME_BITS = SLOTS * BITS_PER_SLOT,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [POS_W-1:0]  rx_offset,
  input  logic [POS_W-1:0]  tx_offset,
  input  logic              tx_link_en,
  input  logic              rx_sd,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              tx_req_valid,
  output logic [SLOT_W-1:0] tx_req_slot,
  input  logic              tx_rsp_valid,
  output logic              tx_rsp_ready,
  input  logic [7:0]        tx_rsp_data,
  input  logic              tx_rsp_drive,
  output logic              tx_sd,
  output logic              tx_oe,
  output logic              frame_slip
);
  localparam int LINKS = 2;  // index 0 receive, 1 transmit

  logic [POS_W-1:0]  cur_pos;
  logic              active;
  logic [POS_W-1:0]  offs     [LINKS];
  logic [2:0]        bit_idx  [LINKS];
  logic [SLOT_W-1:0] slot_idx [LINKS];

  assign offs[0] = rx_offset;
  assign offs[1] = tx_offset;

  tdm_frame_tracker #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .cur_pos(cur_pos), .active(active), .slip(frame_slip)
  );

  for (genvar g = 0; g < LINKS; g++) begin : g_phase
    tdm_link_phase #(.SLOTS(SLOTS)) u_phase (
      .cur_pos(cur_pos), .offset(offs[g]),
      .bit_idx(bit_idx[g]), .slot_idx(slot_idx[g])
    );
  end

  tdm_rx_deser #(.SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(active),
    .bit_idx(bit_idx[0]), .slot_idx(slot_idx[0]), .rx_sd(rx_sd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_slot(rx_slot)
  );

  tdm_tx_ser #(.SLOTS(SLOTS)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(active),
    .bit_idx(bit_idx[1]), .slot_idx(slot_idx[1]), .link_en(tx_link_en),
    .rsp_valid(tx_rsp_valid), .rsp_ready(tx_rsp_ready),
    .rsp_data(tx_rsp_data), .rsp_drive(tx_rsp_drive),
    .req_valid(tx_req_valid), .req_slot(tx_req_slot),
    .tx_sd(tx_sd), .tx_oe(tx_oe)
  );
endmodule

// File: rtl/tdm_link_port_chk.sv
module tdm_link_port_chk (
  input logic clk,
  input logic rst_n,
  input logic fsync,
  input logic tx_link_en,
  input logic rx_valid,
  input logic tx_req_valid,
  input logic tx_rsp_valid,
  input logic tx_rsp_ready,
  input logic tx_sd,
  input logic tx_oe,
  input logic frame_slip
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (fsync) seen_q <= 1'b1;
  end

  AST_SILENT_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || tx_req_valid || tx_oe) |-> seen_q); // R2
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid |=> !tx_req_valid); // R4
  AST_REQ_OPENS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid |-> tx_rsp_ready); // R5
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rsp_valid && tx_rsp_ready) |=> !tx_rsp_ready); // R5
  AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> $past(tx_link_en)); // R8
  AST_SLIP_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_slip |-> $past(fsync)); // R9
  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_sd); // R10
endmodule

bind tdm_link_port tdm_link_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_link_en(tx_link_en),
  .rx_valid(rx_valid), .tx_req_valid(tx_req_valid),
  .tx_rsp_valid(tx_rsp_valid), .tx_rsp_ready(tx_rsp_ready),
  .tx_sd(tx_sd), .tx_oe(tx_oe), .frame_slip(frame_slip)
);

// File: tb/tdm_link_port_tb.sv
module tdm_link_port_tb_top;
  localparam int SLOTS  = 4;
  localparam int F      = SLOTS * 8;
  localparam int POS_W  = $clog2(F);
  localparam int SLOT_W = $clog2(SLOTS);

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, tx_link_en = 1'b0, rx_sd = 1'b0;
  logic tx_rsp_valid = 1'b0, tx_rsp_drive = 1'b0;
  logic [POS_W-1:0] rx_offset = '0, tx_offset = '0;
  logic [7:0] tx_rsp_data = '0;
  logic rx_valid, tx_req_valid, tx_rsp_ready, tx_sd, tx_oe, frame_slip;
  logic [7:0] rx_data;
  logic [SLOT_W-1:0] rx_slot, tx_req_slot;

  tdm_link_port #(.SLOTS(SLOTS)) dut_i (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit running = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_phase, m_rx_sh, m_cur_byte, m_pend, rx_d, rx_s, req_s;
  bit m_locked, m_cur_drive, m_pend_drive, m_pend_v, m_open;
  bit e_rx_v, e_req, e_sd, e_oe, e_slip;
  string rx_tag, tx_tag;

  function automatic int lpos(int off);
    int cp = fsync ? 0 : m_phase;
    return (cp - off + F) % F;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_locked = 0; m_rx_sh = 0; m_cur_byte = 0; m_cur_drive = 0;
      m_pend = 0; m_pend_drive = 0; m_pend_v = 0; m_open = 0;
      e_rx_v = 0; e_req = 0; e_sd = 0; e_oe = 0; e_slip = 0;
    end else begin : model
      int cp, rp, tp;
      bit act, rdy, hs;
      cp  = fsync ? 0 : m_phase;
      act = m_locked || fsync;
      rp  = lpos(int'(rx_offset));
      tp  = lpos(int'(tx_offset));
      rdy = m_open && (tp % 8 != 0);
      hs  = tx_rsp_valid && rdy;
      e_slip = fsync && m_locked && (m_phase != 0);
      rx_tag = act ? "R3" : "R2";
      if (act) m_rx_sh = ((m_rx_sh << 1) | int'(rx_sd)) & 255;
      e_rx_v = act && (rp % 8 == 7);
      if (e_rx_v) begin rx_d = m_rx_sh; rx_s = rp / 8; end
      if (act && tp % 8 == 0) begin
        if (m_pend_v) m_cur_byte = m_pend;
        m_cur_drive = m_pend_v && m_pend_drive;
        m_pend_v = 0; m_open = 1; e_req = 1;
        req_s = (tp / 8 + 1) % SLOTS;
      end else begin
        e_req = 0;
        if (hs) begin
          m_pend = int'(tx_rsp_data); m_pend_drive = tx_rsp_drive;
          m_pend_v = 1; m_open = 0;
        end
      end
      e_oe = act && tx_link_en && m_cur_drive;
      e_sd = e_oe ? ((m_cur_byte >> (7 - tp % 8)) & 1) : 0;
      tx_tag = !act ? "R2" : (!tx_link_en ? "R8" : (!m_cur_drive ? "R7" : "R6"));
      m_locked = m_locked || fsync;
      m_phase = (cp + 1) % F;
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk(rx_tag, "rx_valid", int'(rx_valid), int'(e_rx_v));
      if (e_rx_v) begin
        chk("R3", "rx_data", int'(rx_data), rx_d);
        chk("R3", "rx_slot", int'(rx_slot), rx_s);
      end
      chk(m_locked ? "R4" : "R2", "tx_req_valid", int'(tx_req_valid), int'(e_req));
      if (e_req) chk("R4", "tx_req_slot", int'(tx_req_slot), req_s);
      chk("R5", "tx_rsp_ready", int'(tx_rsp_ready),
          int'(m_open && (lpos(int'(tx_offset)) % 8 != 0)));
      chk(tx_tag, "tx_oe", int'(tx_oe), int'(e_oe));
      chk(tx_tag, "tx_sd", int'(tx_sd), int'(e_sd));
      if (!tx_oe) chk("R10", "tx_sd idle", int'(tx_sd), 0);
      chk("R9", "frame_slip", int'(frame_slip), int'(e_slip));
    end
  end

  // ---------------- stimulus ----------------
  bit sync_on = 0, rq_pend = 0;
  int fs_cnt = 0, rsp_delay = 2, skip_slot = -1, rq_cnt = 0, rq_slot = 0, seq = 0;

  task automatic step();
    @(posedge clk); #1;
    rx_sd = 1'($urandom);
    fsync = sync_on && (fs_cnt == 0);
    fs_cnt = (fs_cnt + 1) % F;
    if (tx_req_valid) begin
      rq_pend = 1; rq_cnt = rsp_delay; rq_slot = int'(tx_req_slot);
    end
    tx_rsp_valid = 1'b0;
    if (rq_pend) begin
      if (rq_cnt == 0) begin
        tx_rsp_valid = 1'b1;
        tx_rsp_data  = 8'(8'h5A ^ (rq_slot * 37) ^ seq);
        tx_rsp_drive = (rq_slot != skip_slot);
        seq++;
        rq_pend = 0;
      end else rq_cnt--;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "tx_req_valid", int'(tx_req_valid), 0);
    chk("R1", "tx_rsp_ready", int'(tx_rsp_ready), 0);
    chk("R1", "tx_oe", int'(tx_oe), 0);
    chk("R1", "tx_sd", int'(tx_sd), 0);
    chk("R1", "frame_slip", int'(frame_slip), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    running = 1;
    tx_link_en = 1'b1;
    run(20);                                 // R2: no frame pulse yet
    sync_on = 1; fs_cnt = 0;
    run(3 * F);                              // R3 R4 R6 aligned lines
    rx_offset = POS_W'(5); tx_offset = POS_W'(F - 1);
    rsp_delay = 6; skip_slot = 2;
    run(4 * F);                              // wrap offset, latest answer, R7 skip
    tx_link_en = 1'b0;
    run(F);                                  // R8
    tx_link_en = 1'b1; skip_slot = -1; rsp_delay = 7;
    run(F);                                  // R7 late answer dropped
    rsp_delay = 3;
    run(20);
    fs_cnt = 0;                              // R9 early pulse
    run(3 * F);
    rx_offset = POS_W'(F - 1); tx_offset = POS_W'(13); rsp_delay = 0;
    run(3 * F);
    running = 0;
    summary();
    $finish;
  end
endmodule